// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective data address into a physical address by searching a hashed page table kept in ordinary memory. The requester supplies the address, a read/write flag, the sixteen per-segment virtual segment identifiers, the table origin and table mask fields, and the result of a data block-translation lookup that runs alongside it. When that lookup hits, its physical address is returned at once. Otherwise the walker builds a primary and a secondary group address from a hash and reads table entries over a word-wide memory port. It reports either a translated physical address or a page fault.

Group addresses come from ORing the table base with the masked, shifted hash. Neither addition nor alignment is enforced. A base that overlaps the mask, or a mask with a zero inside its run of ones, therefore produces aliased group locations, and the walker reproduces them exactly. When an entry matches, its referenced and changed flags are brought up to date in memory. A word is written back only when a flag actually changes.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted only while `busy` is low. `busy` stays high from acceptance through the single-cycle `done` pulse and falls in the cycle after it. Out of reset, `busy`, `done` and `mem_req_valid` are 0.
- R2: If `dbat_hit` is high when a request is accepted, the block returns `pa = dbat_pa` with `fault = 0` and issues no memory request.
- R3: The segment identifier is chosen by address bits [31:28]. The primary hash is `{8'b0,vsid} ^ (addr >> 12)` and the secondary hash is its bitwise complement. The group address is `((hash << 6) & mask) | base`, using OR even when base and mask bits overlap.
- R4: The mask is `{tbl_mask_fld, 16'hFFFF}` and the base is `{tbl_origin, 16'h0000}`. A zero between ones in the mask field drops that offset bit.
- R5: Slot k of a group occupies bytes group+8k. Word 0 holds V[31], VSID[30:7], H[6] and API[5:0]. An entry matches only when V=1, VSID equals the segment identifier, API equals address bits [27:22], and H is 0 for the primary group or 1 for the secondary group.
- R6: Primary slots 0 to 7 are searched before secondary slots 0 to 7, and the first match in that order wins.
- R7: Word 0 of each slot is read in search order. Word 1 (at +4) is read only for the matching slot, so a hit in group g (0 = primary), slot k costs 8g+k+1 word-0 reads and one word-1 read.
- R8: Word 1 holds RPN[31:12], R[8], C[7], WIMG[6:3] and PP[1:0]. The physical address is `{RPN, addr[11:0]}`.
- R9: A read writes word 1 back with R set; a write sets both R and C. All other bits are kept. If the needed bits are already set, no write is issued.
- R10: When none of the 16 slots match, the result is `fault = 1` after exactly 16 word-0 reads, with no word-1 read and no write.
- R11: Memory requests are word-aligned. A request held while `mem_req_ready` is low keeps its address until it is accepted. No request is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | 1 = store access, 0 = load |
| seg_vsid | input | 384 | Sixteen 24-bit segment identifiers, segment i at bits [24i+23:24i] |
| tbl_origin | input | 16 | Table origin field (base = field << 16) |
| tbl_mask_fld | input | 16 | Table mask field (mask upper half) |
| dbat_hit | input | 1 | Data block-translation hit |
| dbat_pa | input | 32 | Physical address from the block-translation hit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| pa | output | 32 | Physical address, valid with done |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bench builds the walker with its defaults: 8-slot groups and 16 segments. It switches among four table configurations at run time: an aligned 64 KiB table, an aligned 128 KiB table, a base that overlaps the mask, and a mask with a hole. Across both aligned tables, every segment is swept with both hash groups at varying slots. The count of word reads then confirms the exact search position. The misaligned and holed settings place an entry where an adding or hole-free walker would look and show that it is missed. The same entry placed at the OR-formed address is then found.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VSID_W   = 24;
    localparam int API_W    = 6;
    localparam int RPN_W    = 20;
    localparam int PG_SHIFT = 12;

    typedef struct packed {
        logic              v;
        logic [VSID_W-1:0] vsid;
        logic              h;
        logic [API_W-1:0]  api;
    } pte_w0_t;

    typedef struct packed {
        logic [RPN_W-1:0] rpn;
        logic [2:0]       rsv_hi;
        logic             ref_b;
        logic             chg_b;
        logic [3:0]       attr;
        logic             rsv_lo;
        logic [1:0]       prot;
    } pte_w1_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_W0_REQ, ST_W0_WAIT, ST_W1_REQ, ST_W1_WAIT, ST_WB_REQ, ST_DONE
    } walk_state_t;

    function automatic logic [31:0] table_mask(input logic [15:0] fld);
        return {fld, 16'hFFFF};
    endfunction

    function automatic logic [31:0] table_base(input logic [15:0] org);
        return {org, 16'h0000};
    endfunction
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash
    import ptw_pkg::*;
#(
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [19:0]       vpage,
    input  logic              secondary,
    input  logic [31:0]       tmask,
    input  logic [31:0]       tbase,
    output logic [31:0]       grp_addr
);
    logic [31:0] prim;
    logic [31:0] sel;

    always_comb begin
        prim     = {{(32-VSID_W){1'b0}}, vsid} ^ {12'h000, vpage};
        sel      = secondary ? ~prim : prim;
        // base merged by OR: overlapping bits alias rather than carry
        grp_addr = ((sel << GRP_SHIFT) & tmask) | tbase;
    end
endmodule

// File: rtl/ptw_match.sv
module ptw_match
    import ptw_pkg::*;
(
    input  pte_w0_t           w0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              secondary,
    output logic              hit
);
    always_comb begin
        hit = w0.v && (w0.vsid == vsid) && (w0.api == api) && (w0.h == secondary);
    end
endmodule

// File: rtl/ptw_update.sv
module ptw_update
    import ptw_pkg::*;
(
    input  pte_w1_t              w1,
    input  logic                 is_write,
    input  logic [PG_SHIFT-1:0]  offset,
    output logic                 need_wb,
    output pte_w1_t              w1_new,
    output logic [31:0]          pa
);
    always_comb begin
        w1_new       = w1;
        w1_new.ref_b = 1'b1;
        if (is_write) begin
            w1_new.chg_b = 1'b1;
        end
        need_wb = (w1_new != w1);
        pa      = {w1.rpn, offset};
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int GROUP_SLOTS = 8,
    parameter int SEG_COUNT   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [31:0]                 req_addr,
    input  logic                        req_write,
    input  logic [SEG_COUNT*VSID_W-1:0] seg_vsid,
    input  logic [15:0]                 tbl_origin,
    input  logic [15:0]                 tbl_mask_fld,
    input  logic                        dbat_hit,
    input  logic [31:0]                 dbat_pa,
    output logic                        busy,
    output logic                        done,
    output logic                        fault,
    output logic [31:0]                 pa,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_we,
    output logic [31:0]                 mem_req_addr,
    output logic [31:0]                 mem_req_wdata,
    input  logic                        mem_rsp_valid,
    input  logic [31:0]                 mem_rsp_rdata
);
    localparam int ENTRY_BYTES = 8;
    localparam int GRP_SHIFT   = $clog2(GROUP_SLOTS * ENTRY_BYTES);
    localparam int SLOT_W      = $clog2(GROUP_SLOTS);
    localparam int SEG_BITS    = $clog2(SEG_COUNT);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

    logic [VSID_W-1:0] seg_arr [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        assign seg_arr[g] = seg_vsid[g*VSID_W +: VSID_W];
    end

    walk_state_t       state;
    logic [31:0]       addr_q;
    logic              wr_q;
    logic [VSID_W-1:0] vsid_q;
    logic [31:0]       mask_q;
    logic [31:0]       base_q;
    logic [SLOT_W-1:0] slot_q;
    logic              sec_q;
    pte_w1_t           w1_q;
    logic [31:0]       pa_q;
    logic              fault_q;

    logic [31:0] grp_addr;
    logic [31:0] ent_addr;
    logic        w0_hit;
    logic        upd_wb;
    pte_w1_t     upd_w1;
    logic [31:0] upd_pa;

    ptw_hash #(.GRP_SHIFT(GRP_SHIFT)) u_hash (
        .vsid      (vsid_q),
        .vpage     (addr_q[31:12]),
        .secondary (sec_q),
        .tmask     (mask_q),
        .tbase     (base_q),
        .grp_addr  (grp_addr)
    );

    ptw_match u_match (
        .w0        (pte_w0_t'(mem_rsp_rdata)),
        .vsid      (vsid_q),
        .api       (addr_q[27:22]),
        .secondary (sec_q),
        .hit       (w0_hit)
    );

    ptw_update u_upd (
        .w1        (pte_w1_t'(mem_rsp_rdata)),
        .is_write  (wr_q),
        .offset    (addr_q[PG_SHIFT-1:0]),
        .need_wb   (upd_wb),
        .w1_new    (upd_w1),
        .pa        (upd_pa)
    );

    assign ent_addr = grp_addr + (32'(slot_q) << $clog2(ENTRY_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            vsid_q  <= '0;
            mask_q  <= '0;
            base_q  <= '0;
            slot_q  <= '0;
            sec_q   <= 1'b0;
            w1_q    <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wr_q    <= req_write;
                        vsid_q  <= seg_arr[req_addr[31 -: SEG_BITS]];
                        mask_q  <= table_mask(tbl_mask_fld);
                        base_q  <= table_base(tbl_origin);
                        slot_q  <= '0;
                        sec_q   <= 1'b0;
                        fault_q <= 1'b0;
                        if (dbat_hit) begin
                            pa_q  <= dbat_pa;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_W0_REQ;
                        end
                    end
                end
                ST_W0_REQ: if (mem_req_ready) state <= ST_W0_WAIT;
                ST_W0_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (w0_hit) begin
                            state <= ST_W1_REQ;
                        end else if (slot_q == LAST_SLOT) begin
                            if (sec_q) begin
                                fault_q <= 1'b1;
                                pa_q    <= '0;
                                state   <= ST_DONE;
                            end else begin
                                sec_q  <= 1'b1;
                                slot_q <= '0;
                                state  <= ST_W0_REQ;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            state  <= ST_W0_REQ;
                        end
                    end
                end
                ST_W1_REQ: if (mem_req_ready) state <= ST_W1_WAIT;
                ST_W1_WAIT: begin
                    if (mem_rsp_valid) begin
                        pa_q  <= upd_pa;
                        w1_q  <= upd_w1;
                        state <= upd_wb ? ST_WB_REQ : ST_DONE;
                    end
                end
                ST_WB_REQ: if (mem_req_ready) state <= ST_DONE;
                ST_DONE:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        fault         = fault_q;
        pa            = pa_q;
        mem_req_valid = (state == ST_W0_REQ) || (state == ST_W1_REQ) || (state == ST_WB_REQ);
        mem_req_we    = (state == ST_WB_REQ);
        mem_req_addr  = ent_addr + ((state == ST_W0_REQ) ? 32'd0 : 32'd4);
        mem_req_wdata = w1_q;
    end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [31:0] mem_req_addr
);
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);  // R1
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));  // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);  // R11
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));  // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));  // R11
    AST_WB_SECOND_WORD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> mem_req_addr[2]);  // R9
endmodule

bind pt_walker ptw_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [383:0] seg_vsid;
    logic [15:0] tbl_origin = 16'h0002;
    logic [15:0] tbl_mask_fld = 16'h0000;
    logic        dbat_hit = 1'b0;
    logic [31:0] dbat_pa = '0;
    logic        busy, done, fault;
    logic [31:0] pa;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    logic [23:0] seg_tab [16];
    logic [31:0] mem [int unsigned];
    int n_rd0, n_rd1, n_wr;
    int checks = 0;
    int errors = 0;

    pt_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .seg_vsid(seg_vsid), .tbl_origin(tbl_origin),
        .tbl_mask_fld(tbl_mask_fld), .dbat_hit(dbat_hit), .dbat_pa(dbat_pa),
        .busy(busy), .done(done), .fault(fault), .pa(pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    always_comb begin
        for (int i = 0; i < 16; i++) seg_vsid[i*24 +: 24] = seg_tab[i];
    end

    function automatic logic [31:0] rdmem(input logic [31:0] a);
        if (mem.exists(a >> 2)) return mem[a >> 2];
        return 32'h0;
    endfunction

    // memory model: ready pattern with stalls, read data one cycle after acceptance
    initial begin
        logic        p_acc;
        logic        p_we;
        logic [31:0] p_addr, p_wd;
        int          cyc;
        p_acc = 0; p_we = 0; p_addr = 0; p_wd = 0; cyc = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (p_acc) begin
                if (p_we) begin
                    mem[p_addr >> 2] = p_wd;
                    n_wr++;
                end else begin
                    mem_rsp_valid = 1;
                    mem_rsp_rdata = rdmem(p_addr);
                    if (p_addr[2]) n_rd1++; else n_rd0++;
                end
            end
            cyc++;
            mem_req_ready = (cyc % 3) != 1;
            p_acc  = mem_req_valid && mem_req_ready && !rst;
            p_we   = mem_req_we;
            p_addr = mem_req_addr;
            p_wd   = mem_req_wdata;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete act=%0d exp=%0d", 0, 1);
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic [31:0] a, input bit s,
                                        input logic [15:0] org, input logic [15:0] mf, input bit use_add);
        logic [31:0] h, off;
        h = {8'h0, seg_tab[a[31:28]]} ^ {12'h0, a[31:12]};
        if (s) h = ~h;
        off = (h << 6) & {mf, 16'hFFFF};
        return use_add ? (off + {org, 16'h0}) : (off | {org, 16'h0});
    endfunction

    function automatic logic [31:0] w0_of(input logic [31:0] a, input bit s);
        return {1'b1, seg_tab[a[31:28]], s, a[27:22]};
    endfunction

    function automatic logic [31:0] w1_of(input logic [19:0] rpn, input bit r, input bit c);
        return {rpn, 3'b000, r, c, 4'b0000, 1'b0, 2'b10};
    endfunction

    task automatic put(input logic [31:0] ea, input logic [31:0] w0, input logic [31:0] w1);
        mem[ea >> 2] = w0;
        mem[(ea >> 2) + 1] = w1;
    endtask

    task automatic xlate(input logic [31:0] a, input bit we, input bit bat, input logic [31:0] bpa,
                         output logic [31:0] o_pa, output bit o_f, output bit o_busy, output bit o_after);
        @(negedge clk);
        n_rd0 = 0; n_rd1 = 0; n_wr = 0;
        req_addr = a; req_write = we; dbat_hit = bat; dbat_pa = bpa; req_valid = 1;
        @(negedge clk);
        req_valid = 0; dbat_hit = 0;
        while (!done) @(negedge clk);
        o_pa = pa; o_f = fault; o_busy = busy;
        @(negedge clk);
        o_after = busy;
    endtask

    task automatic alias_case(input logic [15:0] org, input logic [15:0] mf,
                              input logic [15:0] alt_mf, input bit use_add, input string tag);
        logic [31:0] a, eg, ea, rp;
        bit f, b0, b1;
        int differ;
        differ = 0;
        tbl_origin = org; tbl_mask_fld = mf;
        for (int k = 0; k < 2; k++) begin
            a = 32'h10A30123 + k * 32'h00400000;
            eg = grp(a, 0, org, mf, 0);
            ea = grp(a, 0, org, alt_mf, use_add);
            mem.delete();
            if (ea != eg) begin
                differ++;
                put(ea, w0_of(a, 0), w1_of(20'h00230, 1, 1));
                xlate(a, 0, 0, 0, rp, f, b0, b1);
                chk(f == 1, {tag, " R3 alternative group must miss"}, 32'(f), 1);
                mem.delete();
            end
            put(eg, w0_of(a, 0), w1_of(20'h00260, 1, 1));
            xlate(a, 0, 0, 0, rp, f, b0, b1);
            chk(!f && rp == 32'h00260123, {tag, " R3 OR-formed group hit"}, rp, 32'h00260123);
        end
        chk(differ > 0, {tag, " R4 aliasing configuration exercised"}, differ, 1);
    endtask

    initial begin
        logic [31:0] a, g, gs, rp, exp_pa;
        logic [19:0] rpn;
        bit f, b0, b1;
        int slot;

        for (int i = 0; i < 16; i++) seg_tab[i] = 24'h3C5000 ^ (24'(i) * 24'h0101A7);

        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req_valid == 0, "R1 reset state",
            {busy, done, mem_req_valid}, 0);
        rst = 0;
        repeat (2) @(negedge clk);

        // R2: block translation hit bypasses table
        a = 32'h10100ABC;
        put(grp(a, 0, 16'h0002, 16'h0, 0), w0_of(a, 0), w1_of(20'h00777, 1, 1));
        xlate(a, 0, 1, 32'h00ABC123, rp, f, b0, b1);
        chk(rp == 32'h00ABC123 && !f, "R2 block hit address", rp, 32'h00ABC123);
        chk(n_rd0 == 0 && n_rd1 == 0 && n_wr == 0, "R2 no memory traffic", n_rd0 + n_rd1 + n_wr, 0);
        chk(b0 == 1 && b1 == 0, "R1 busy through done then low", {b0, b1}, 2'b10);

        // R10: empty table faults
        mem.delete();
        xlate(32'h20130456, 0, 0, 0, rp, f, b0, b1);
        chk(f == 1, "R10 fault flag", 32'(f), 1);
        chk(n_rd0 == 16 && n_rd1 == 0 && n_wr == 0, "R10 R7 sixteen probes no write", n_rd0, 16);

        // R9: referenced/changed write-back
        mem.delete();
        a = 32'h101F0123;
        g = grp(a, 0, 16'h0002, 16'h0, 0);
        put(g, w0_of(a, 0), w1_of(20'h001F0, 0, 0));
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(!f && rp == 32'h001F0123, "R8 physical address", rp, 32'h001F0123);
        chk(n_wr == 1 && rdmem(g + 4) == w1_of(20'h001F0, 1, 0), "R9 read sets R only",
            rdmem(g + 4), w1_of(20'h001F0, 1, 0));
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(n_wr == 0, "R9 no write when R already set", n_wr, 0);
        xlate(a, 1, 0, 0, rp, f, b0, b1);
        chk(n_wr == 1 && rdmem(g + 4) == w1_of(20'h001F0, 1, 1), "R9 store sets C",
            rdmem(g + 4), w1_of(20'h001F0, 1, 1));
        xlate(a, 1, 0, 0, rp, f, b0, b1);
        chk(n_wr == 0, "R9 no write when R and C set", n_wr, 0);
        a = 32'h10200FFF;
        g = grp(a, 0, 16'h0002, 16'h0, 0);
        put(g, w0_of(a, 0), w1_of(20'h00ABC, 0, 0));
        xlate(a, 1, 0, 0, rp, f, b0, b1);
        chk(n_wr == 1 && rdmem(g + 4) == w1_of(20'h00ABC, 1, 1), "R9 store on fresh entry sets both",
            rdmem(g + 4), w1_of(20'h00ABC, 1, 1));

        // R6: search order
        mem.delete();
        a = 32'h10180010;
        g = grp(a, 0, 16'h0002, 16'h0, 0);
        gs = grp(a, 1, 16'h0002, 16'h0, 0);
        put(g + 16, w0_of(a, 0), w1_of(20'h00180, 1, 1));
        put(g + 32, w0_of(a, 0), w1_of(20'h001A0, 1, 1));
        put(gs, w0_of(a, 1), w1_of(20'h00190, 1, 1));
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(rp == 32'h00180010 && n_rd0 == 3, "R6 lowest primary slot wins", rp, 32'h00180010);
        mem[(g + 16) >> 2] = w0_of(a, 0) & 32'h7FFFFFFF;
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(rp == 32'h001A0010 && n_rd0 == 5, "R6 next primary after removal", rp, 32'h001A0010);
        mem[(g + 32) >> 2] = 32'h0;
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(rp == 32'h00190010 && n_rd0 == 9, "R6 fall back to secondary", rp, 32'h00190010);
        put(g + 56, w0_of(a, 0), w1_of(20'h001B0, 1, 1));
        xlate(a, 0, 0, 0, rp, f, b0, b1);
        chk(rp == 32'h001B0010 && n_rd0 == 8, "R6 primary slot 7 beats secondary slot 0", rp, 32'h001B0010);

        // R5: each mismatching field prevents a match
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w0;
            mem.delete();
            a = 32'h30456789;
            w0 = w0_of(a, 0);
            case (k)
                0: w0[31] = 1'b0;
                1: w0[7] = ~w0[7];
                2: w0[0] = ~w0[0];
                default: w0[6] = 1'b1;
            endcase
            put(grp(a, 0, 16'h0002, 16'h0, 0), w0, w1_of(20'h00111, 1, 1));
            xlate(a, 0, 0, 0, rp, f, b0, b1);
            chk(f == 1 && n_rd1 == 0, $sformatf("R5 mismatch field %0d", k), 32'(f), 1);
        end

        // R3 R4 R7 R8 sweep over segments, groups and slots for two aligned tables
        for (int cfg = 0; cfg < 2; cfg++) begin
            logic [15:0] org, mf;
            org = (cfg == 0) ? 16'h0002 : 16'h0004;
            mf  = (cfg == 0) ? 16'h0000 : 16'h0001;
            tbl_origin = org; tbl_mask_fld = mf;
            for (int s = 0; s < 16; s++) begin
                for (int sec = 0; sec < 2; sec++) begin
                    mem.delete();
                    a = {4'(s), 28'h0} | (((32'(s) * 32'h3B + 32'(sec) * 32'h1C7 + 32'(cfg) * 32'h400) << 12) & 32'h0FFFF000)
                        | ((32'(s) * 32'h55) & 32'hFFF);
                    slot = (s + 3 * sec + cfg) % 8;
                    if (sec == 1) begin
                        for (int j = 0; j < 8; j++)
                            put(grp(a, 0, org, mf, 0) + 32'(j) * 8, w0_of(a, 0) ^ 32'h1, w1_of(20'h0, 1, 1));
                    end
                    rpn = 20'({s, 4'(sec), 4'(slot)}) + 20'(cfg) * 20'h10000;
                    put(grp(a, sec[0], org, mf, 0) + 32'(slot) * 8, w0_of(a, sec[0]), w1_of(rpn, 1, 1));
                    exp_pa = {rpn, a[11:0]};
                    xlate(a, 0, 0, 0, rp, f, b0, b1);
                    chk(!f && rp == exp_pa, $sformatf("R3 R4 R8 cfg%0d seg%0d grp%0d", cfg, s, sec), rp, exp_pa);
                    chk(n_rd0 == sec * 8 + slot + 1 && n_rd1 == 1 && n_wr == 0,
                        $sformatf("R7 probe count cfg%0d seg%0d grp%0d", cfg, s, sec), n_rd0, sec * 8 + slot + 1);
                end
            end
        end

        // R3 R4: misaligned base and holed mask aliasing
        alias_case(16'h0005, 16'h0003, 16'h0003, 1, "misaligned base");
        alias_case(16'h0008, 16'h0002, 16'h0003, 0, "holed mask");

        summary();
    end
endmodule